// File: doc/BRIEF.md
# Power-Mode Sequencer with Divided CPU Clock Enable

This block tracks the power mode of a small microcontroller core and produces the enable for the core's clock. The core runs at full speed (high-speed) or on a divided clock (medium-speed). It can be parked in sleep or in software standby by a sleep strobe. It is forced into hardware standby or the reset state by pins or by a watchdog overflow. The divided rate is given as a single-cycle clock-enable pulse on the undivided system clock. Peripherals that are not bus masters keep a steady enable in every mode where they run.

A new divider setting does not take effect when it is written. It waits for the strobe that marks the end of the current bus cycle, and the enable counter then restarts from zero so that no pulse comes out short. Leaving sleep or software standby brings the core back to the speed it had before, because the applied divider is kept through the low-power state. Hardware standby takes priority over everything else. Leaving it always passes through one cycle of the reset state, and that cycle clears the divider.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `rst_n` is low with `stby_n` high, `mode_o` is 5 (reset) and `div_act_o` is 0. In the first clock after `rst_n` is sampled high, `mode_o` becomes 0 (high-speed).
- R2: The applied divider `div_act_o` takes a new `div_sel` value only at a clock edge where `bus_end` is high and the core is running (mode 0 or 1). The select codes are 000 = /1, 001 = /2, 010 = /4, 011 = /8, 100 = /16 and 101 = /32. Codes 110 and 111 are applied and reported as 101.
- R3: A zero select, once applied at a bus-cycle end, makes `mode_o` 0 (high-speed). Any nonzero applied divider gives `mode_o` 1 (medium-speed).
- R4: While running with applied code k, `cpu_clk_en_o` is a single-cycle pulse every 2^k system clocks, or high every cycle when k = 0. After a new code is applied, its first pulse comes in the 2^k-th cycle after that edge. With code 010, one CPU state lasts 4 system clocks and a two-state access lasts 8.
- R5: `periph_clk_en_o` is high in modes 0, 1 and 2 whatever the divider, and low in modes 3, 4 and 5.
- R6: `sleep_req` while running, with `stby_en` = 0 and `lson` = 0, gives `mode_o` 2 (sleep) on the next cycle. Any bit of `irq_int` or `irq_ext` then returns the core to the mode it slept from, with the divider unchanged.
- R7: `sleep_req` while running, with `stby_en` = 1, `lson` = 0 and `wdt_sel` = 0, gives `mode_o` 3 (software standby). Only a bit of `irq_ext` leaves it, back to the prior speed mode. `irq_int` has no effect there.
- R8: `sleep_req` with `lson` = 1, or with `stby_en` = 1 and `wdt_sel` = 1, is ignored: the mode stays as it was.
- R9: `wdt_ovf` high with `stby_n` high forces `mode_o` 5 on the next cycle from any mode. Reset lasts one cycle once `wdt_ovf` drops, then the core runs at high-speed.
- R10: `stby_n` low forces `mode_o` 4 (hardware standby) with `pad_oe_o` low, even while `rst_n` is low or `wdt_ovf` is high. After `stby_n` rises, the mode goes to 5 for one cycle and then to 0.
- R11: `cpu_clk_en_o` is low in every mode other than 0 and 1.
- R12: `bus_end` and `div_sel` have no effect on `div_act_o` outside modes 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Reset pin, active low, sampled synchronously |
| stby_n | input | 1 | Hardware standby pin, active low |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| div_sel | input | 3 | Requested clock divider code |
| stby_en | input | 1 | Sleep strobe enters standby instead of sleep |
| lson | input | 1 | Low-speed-on control bit |
| wdt_sel | input | 1 | Watchdog-select control bit |
| sleep_req | input | 1 | Sleep instruction strobe |
| bus_end | input | 1 | Current bus cycle ends this clock |
| irq_int | input | N_INT | Internal interrupt requests |
| irq_ext | input | N_EXT | External interrupt requests |
| mode_o | output | 3 | Current mode: 0 high, 1 medium, 2 sleep, 3 sw standby, 4 hw standby, 5 reset |
| div_act_o | output | 3 | Divider code currently applied |
| cpu_clk_en_o | output | 1 | CPU clock enable pulse |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| pad_oe_o | output | 1 | Output pad enable, low in hardware standby |

## Verification
The assertions check four things on every cycle: the applied divider changes only after a bus-cycle end or a reset, an enable pulse under a nonzero divider is never followed by a second one, software standby is left only on an external interrupt or a pin event, and hardware standby can only be followed by itself or reset. The watchdog path into reset is checked the same way. Only the bench's scenarios can show the rest. That covers the pulse spacing and the restart phase after a divider change, the return to the exact prior speed after a wake-up, the ignored sleep requests, and hardware standby winning over an active reset pin. The bench covers these by comparing all outputs with a behavioural model on every clock.

// File: rtl/pms_pkg.sv
// Package: shared widths, mode codes and the divider-code normaliser for the
// power-mode sequencer. Assumes divider codes above MAX_SHIFT mean MAX_SHIFT.
package pms_pkg;
    localparam int DIV_W     = 3;
    localparam int MAX_SHIFT = 5;
    localparam int CNT_W     = MAX_SHIFT;

    typedef enum logic [2:0] {
        PM_HIGH  = 3'd0,
        PM_MED   = 3'd1,
        PM_SLEEP = 3'd2,
        PM_SSTBY = 3'd3,
        PM_HSTBY = 3'd4,
        PM_RESET = 3'd5
    } pm_mode_e;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_SLEEP = 3'd1,
        ST_SSTBY = 3'd2,
        ST_HSTBY = 3'd3,
        ST_RESET = 3'd4
    } pm_state_e;

    function automatic logic [DIV_W-1:0] norm_div(input logic [DIV_W-1:0] code);
        return (int'(code) > MAX_SHIFT) ? DIV_W'(MAX_SHIFT) : code;
    endfunction
endpackage

// File: rtl/pms_div_sync.sv
// Divider synchroniser: holds the applied divider code and loads the
// requested one only at a bus-cycle end while the core runs.
// Assumes bus_end is a one-cycle strobe from the bus master.
module pms_div_sync
    import pms_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             bus_end,
    input  logic             run,
    input  logic             in_reset,
    output logic [DIV_W-1:0] div_q,
    output logic             apply_o
);
    logic [DIV_W-1:0] sel_norm;

    // Normalise the request and decide whether it takes effect this edge.
    always_comb begin
        sel_norm = norm_div(div_sel);
        apply_o  = run && bus_end && (sel_norm != div_q);
    end

    // Applied divider register, cleared by the reset state.
    always_ff @(posedge clk) begin
        if (!rst_n)        div_q <= '0;
        else if (in_reset) div_q <= '0;
        else if (apply_o)  div_q <= sel_norm;
    end

    // R2
    div_change_at_bus_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_q) |-> (($past(bus_end) && $past(run)) || $past(in_reset)));
endmodule

// File: rtl/pms_clk_gen.sv
// CPU clock-enable generator: a free-running counter produces one pulse per
// 2^div_q system clocks while running. Restarts at zero when a new divider
// applies so that the first period is complete. Assumes div_q <= MAX_SHIFT.
module pms_clk_gen
    import pms_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_q,
    output logic             cpu_en
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   period;
    logic             at_last;

    // Period length and terminal count for the applied code.
    always_comb begin
        period  = (CNT_W+1)'(1) << div_q;
        at_last = (cnt_q == CNT_W'(period - (CNT_W+1)'(1)));
        cpu_en  = run && at_last;
    end

    // Phase counter: held at zero when idle, restarted on divider change.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (!run)    cnt_q <= '0;
        else if (restart) cnt_q <= '0;
        else if (at_last) cnt_q <= '0;
        else              cnt_q <= cnt_q + CNT_W'(1);
    end

    // R4
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_en && div_q != '0) |=> (!cpu_en || div_q == '0));
endmodule

// File: rtl/pms_mode_fsm.sv
// Mode state machine: standby pin over reset/watchdog over sleep and wake-up.
// Leaving hardware standby always passes one cycle through reset.
// Assumes pins are already synchronised to clk.
module pms_mode_fsm
    import pms_pkg::*;
#(
    parameter int N_INT = 4,
    parameter int N_EXT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stby_n,
    input  logic             wdt_ovf,
    input  logic             sleep_req,
    input  logic             stby_en,
    input  logic             lson,
    input  logic             wdt_sel,
    input  logic [N_INT-1:0] irq_int,
    input  logic [N_EXT-1:0] irq_ext,
    output pm_state_e        state_q
);
    pm_state_e state_d;
    logic      any_ext;
    logic      any_irq;

    // Next-state decision in priority order.
    always_comb begin
        any_ext = |irq_ext;
        any_irq = any_ext || (|irq_int);
        state_d = state_q;
        if (!stby_n)                     state_d = ST_HSTBY;
        else if (state_q == ST_HSTBY)    state_d = ST_RESET;
        else if (wdt_ovf)                state_d = ST_RESET;
        else begin
            unique case (state_q)
                ST_RESET: state_d = ST_RUN;
                ST_RUN: begin
                    if (sleep_req && !lson) begin
                        if (!stby_en)      state_d = ST_SLEEP;
                        else if (!wdt_sel) state_d = ST_SSTBY;
                    end
                end
                ST_SLEEP: if (any_irq) state_d = ST_RUN;
                ST_SSTBY: if (any_ext) state_d = ST_RUN;
                default:  state_d = ST_RESET;
            endcase
        end
    end

    // State register; the reset pin yields to the standby pin.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= stby_n ? ST_RESET : ST_HSTBY;
        else        state_q <= state_d;
    end

    // R7
    sstby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SSTBY && stby_n && !wdt_ovf && irq_ext == '0) |=> state_q == ST_SSTBY);

    // R9
    wdt_to_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_ovf && stby_n) |=> state_q == ST_RESET);

    // R10
    hstby_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_HSTBY |=> (state_q == ST_HSTBY || state_q == ST_RESET));
endmodule

// File: rtl/pwr_mode_seq.sv
// Power-mode sequencer top: joins the mode FSM, divider synchroniser and
// clock-enable generator, and maps the internal state onto the external mode code.
// Assumes all inputs are synchronous to clk.
module pwr_mode_seq
    import pms_pkg::*;
#(
    parameter int N_INT = 4,
    parameter int N_EXT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stby_n,
    input  logic             wdt_ovf,
    input  logic [2:0]       div_sel,
    input  logic             stby_en,
    input  logic             lson,
    input  logic             wdt_sel,
    input  logic             sleep_req,
    input  logic             bus_end,
    input  logic [N_INT-1:0] irq_int,
    input  logic [N_EXT-1:0] irq_ext,
    output logic [2:0]       mode_o,
    output logic [2:0]       div_act_o,
    output logic             cpu_clk_en_o,
    output logic             periph_clk_en_o,
    output logic             pad_oe_o
);
    pm_state_e        state;
    logic [DIV_W-1:0] div_q;
    logic             apply;
    logic             run;
    logic             in_reset;
    pm_mode_e         mode;

    assign run      = (state == ST_RUN);
    assign in_reset = (state == ST_RESET);

    pms_mode_fsm #(.N_INT(N_INT), .N_EXT(N_EXT)) fsm_i (
        .clk(clk), .rst_n(rst_n), .stby_n(stby_n), .wdt_ovf(wdt_ovf),
        .sleep_req(sleep_req), .stby_en(stby_en), .lson(lson), .wdt_sel(wdt_sel),
        .irq_int(irq_int), .irq_ext(irq_ext), .state_q(state)
    );

    pms_div_sync div_i (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .bus_end(bus_end),
        .run(run), .in_reset(in_reset), .div_q(div_q), .apply_o(apply)
    );

    pms_clk_gen gen_i (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(apply),
        .div_q(div_q), .cpu_en(cpu_clk_en_o)
    );

    // Map internal state to the external mode code and pad/peripheral enables.
    always_comb begin
        unique case (state)
            ST_RUN:   mode = (div_q == '0) ? PM_HIGH : PM_MED;
            ST_SLEEP: mode = PM_SLEEP;
            ST_SSTBY: mode = PM_SSTBY;
            ST_HSTBY: mode = PM_HSTBY;
            default:  mode = PM_RESET;
        endcase
        mode_o          = mode;
        div_act_o       = div_q;
        periph_clk_en_o = (state == ST_RUN) || (state == ST_SLEEP);
        pad_oe_o        = (state != ST_HSTBY);
    end
endmodule

// File: tb/pwr_mode_seq_tb.sv
module pwr_mode_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_INT = 4;
    localparam int N_EXT = 2;
    localparam int WATCHDOG = 20000;

    logic clk = 0;
    logic rst_n, stby_n, wdt_ovf, stby_en, lson, wdt_sel, sleep_req, bus_end;
    logic [2:0] div_sel;
    logic [N_INT-1:0] irq_int;
    logic [N_EXT-1:0] irq_ext;
    logic [2:0] mode_o, div_act_o;
    logic cpu_clk_en_o, periph_clk_en_o, pad_oe_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    // behavioural reference: 0 run, 2 sleep, 3 sstby, 4 hstby, 5 reset
    int m_st = 5;
    int m_div = 0;
    int m_phase = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_mode_seq #(.N_INT(N_INT), .N_EXT(N_EXT)) dut_i (
        .clk(clk), .rst_n(rst_n), .stby_n(stby_n), .wdt_ovf(wdt_ovf),
        .div_sel(div_sel), .stby_en(stby_en), .lson(lson), .wdt_sel(wdt_sel),
        .sleep_req(sleep_req), .bus_end(bus_end), .irq_int(irq_int), .irq_ext(irq_ext),
        .mode_o(mode_o), .div_act_o(div_act_o), .cpu_clk_en_o(cpu_clk_en_o),
        .periph_clk_en_o(periph_clk_en_o), .pad_oe_o(pad_oe_o)
    );

    function automatic int exp_mode();
        if (m_st == 0) return (m_div == 0) ? 0 : 1;
        return m_st;
    endfunction

    function automatic bit exp_en();
        return (m_st == 0) && (((m_phase + 1) % (1 << m_div)) == 0);
    endfunction

    // Reference model update from the inputs seen at this edge.
    always @(posedge clk) begin
        int nst, ndiv, nph, req;
        nst = m_st; ndiv = m_div; nph = m_phase;
        if (!rst_n) begin
            nst = stby_n ? 5 : 4; ndiv = 0; nph = 0;
        end else begin
            if (m_st == 5) ndiv = 0;
            if (m_st != 0) nph = 0;
            else begin
                req = (div_sel > 5) ? 5 : int'(div_sel);
                if (bus_end && req != m_div) begin ndiv = req; nph = 0; end
                else nph = (m_phase + 1) % (1 << m_div);
            end
            if (!stby_n) nst = 4;
            else if (m_st == 4) nst = 5;
            else if (wdt_ovf) nst = 5;
            else if (m_st == 5) nst = 0;
            else if (m_st == 0) begin
                if (sleep_req && !lson && !stby_en) nst = 2;
                else if (sleep_req && !lson && stby_en && !wdt_sel) nst = 3;
            end else if (m_st == 2) begin
                if (irq_int != 0 || irq_ext != 0) nst = 0;
            end else if (m_st == 3) begin
                if (irq_ext != 0) nst = 0;
            end
        end
        m_st = nst; m_div = ndiv; m_phase = nph;
    end

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Compare all outputs against the model, sampled at the falling edge.
    task automatic compare_all();
        chk(int'(mode_o), exp_mode(), "R6 mode vs model");
        chk(int'(div_act_o), m_div, "R2 divider vs model");
        chk(int'(cpu_clk_en_o), int'(exp_en()), "R4 cpu enable vs model");
        chk(int'(periph_clk_en_o), int'(m_st == 0 || m_st == 2), "R5 periph enable vs model");
        chk(int'(pad_oe_o), int'(m_st != 4), "R10 pad enable vs model");
        if (m_st != 0) chk(int'(cpu_clk_en_o), 0, "R11 no cpu enable when idle");
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic pulse_bus_end(input logic [2:0] code);
        div_sel = code; bus_end = 1; tick(); bus_end = 0;
    endtask

    task automatic count_pulses(input int n, input int exp, input string tag);
        int cnt = 0;
        for (int i = 0; i < n; i++) begin tick(); cnt += int'(cpu_clk_en_o); end
        chk(cnt, exp, tag);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; stby_n = 1; wdt_ovf = 0; div_sel = 0; stby_en = 0; lson = 0;
        wdt_sel = 0; sleep_req = 0; bus_end = 0; irq_int = '0; irq_ext = '0;
        tick(3);
        chk(int'(mode_o), 5, "R1 reset mode");
        chk(int'(div_act_o), 0, "R1 reset divider");
        rst_n = 1; tick();
        chk(int'(mode_o), 0, "R1 high-speed after reset");

        // divider waits for bus end
        div_sel = 3'b010; tick(3);
        chk(int'(div_act_o), 0, "R2 no change before bus end");
        pulse_bus_end(3'b010);
        chk(int'(div_act_o), 2, "R2 applied at bus end");
        chk(int'(mode_o), 1, "R3 medium-speed with nonzero divider");
        count_pulses(16, 4, "R4 four pulses in 16 clocks at /4");

        // out-of-range code saturates
        pulse_bus_end(3'b111);
        chk(int'(div_act_o), 5, "R2 code 111 reported as 101");
        count_pulses(64, 2, "R4 two pulses in 64 clocks at /32");
        pulse_bus_end(3'b001);
        count_pulses(10, 5, "R4 five pulses in 10 clocks at /2");

        // sleep and wake by internal interrupt
        sleep_req = 1; tick(); sleep_req = 0;
        chk(int'(mode_o), 2, "R6 sleep entered");
        chk(int'(cpu_clk_en_o), 0, "R11 cpu enable off in sleep");
        chk(int'(periph_clk_en_o), 1, "R5 peripherals run in sleep");
        pulse_bus_end(3'b000);
        chk(int'(div_act_o), 1, "R12 bus end ignored in sleep");
        div_sel = 3'b001;
        irq_int = 4'b0100; tick(); irq_int = '0;
        chk(int'(mode_o), 1, "R6 wake to prior medium speed");

        // ignored sleep requests
        lson = 1; sleep_req = 1; tick(); sleep_req = 0; lson = 0;
        chk(int'(mode_o), 1, "R8 low-speed-on request ignored");
        stby_en = 1; wdt_sel = 1; sleep_req = 1; tick(); sleep_req = 0; wdt_sel = 0;
        chk(int'(mode_o), 1, "R8 watchdog-select request ignored");

        // software standby
        sleep_req = 1; tick(); sleep_req = 0; stby_en = 0;
        chk(int'(mode_o), 3, "R7 software standby entered");
        chk(int'(periph_clk_en_o), 0, "R5 peripherals stopped in standby");
        irq_int = 4'b1111; tick(2); irq_int = '0;
        chk(int'(mode_o), 3, "R7 internal interrupt ignored");
        irq_ext = 2'b10; tick(); irq_ext = '0;
        chk(int'(mode_o), 1, "R7 external interrupt wakes to medium");

        // back to high speed
        pulse_bus_end(3'b000);
        chk(int'(mode_o), 0, "R3 high-speed at bus end");
        count_pulses(5, 5, "R4 enable every cycle at full speed");

        // watchdog
        pulse_bus_end(3'b011);
        wdt_ovf = 1; tick(); wdt_ovf = 0;
        chk(int'(mode_o), 5, "R9 watchdog reset");
        tick();
        chk(int'(mode_o), 0, "R9 high speed after watchdog reset");
        chk(int'(div_act_o), 0, "R9 divider cleared");

        // hardware standby over reset pin and watchdog
        div_sel = 3'b000;
        stby_n = 0; wdt_ovf = 1; tick(); wdt_ovf = 0;
        chk(int'(mode_o), 4, "R10 hardware standby");
        chk(int'(pad_oe_o), 0, "R10 pads disabled");
        rst_n = 0; tick(2);
        chk(int'(mode_o), 4, "R10 standby wins over reset pin");
        rst_n = 1; tick();
        stby_n = 1; tick();
        chk(int'(mode_o), 5, "R10 exit through reset");
        tick();
        chk(int'(mode_o), 0, "R10 then high speed");
        tick(4);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule